// File: doc/BRIEF.md
# Split-Transaction Pipelined Bus Master

This block sits between a single client and a set of bus slaves and runs every bus access as two separate handshakes. In the first, the master presents a command (address, direction, write data) and the selected slave acknowledges once it has captured that command. In the second, which comes later, the slave acknowledges completion and, for a read, returns the data. Once a command has been accepted, the client may present the next one straight away. The master lets many commands to one slave be in flight together, so that slave can be pipelined to any depth.

Slaves are selected by the top address bits. When the client moves to a different slave, the master allows at most one older transaction to stay unfinished on the slave it is leaving. In the strict policy it allows none. A single tag register remembers that leftover slave. The tag drives a per-slave data-return enable and the return multiplexer, so completions reach the client in the order the commands were accepted and no queue of pending slaves is needed. The client interface is a valid/stall request port plus a response strobe that carries the returned data and the index of the answering slave.

Top module: `stm_split_master`

## Requirements
- R1: After reset nothing is outstanding. `bus_valid` and `rsp_valid` are low while `req_valid` is low, and `bus_dret_en` enables only slave 0.
- R2: `bus_sel` equals the top log2(NSLV) bits of `req_addr`. `bus_addr`, `bus_we` and `bus_wdata` carry the client request unchanged.
- R3: A request is accepted in a cycle when `bus_valid` is high and the selected slave raises its bit of `bus_addr_ack`. `req_stall` is low in exactly the cycles where `req_valid` is high and the request is accepted.
- R4: Requests to the current slave are issued while fewer than MAX_OUT of its transactions are outstanding. When MAX_OUT are outstanding, `bus_valid` stays low.
- R5: In the relaxed policy, a request to a slave other than the current one is issued only when the current slave has at most one transaction outstanding. After that request is accepted, the new slave becomes current with one transaction outstanding.
- R6: While a transaction on a previous slave is outstanding, no request to any slave other than the current one is issued. At most two slaves ever have transactions outstanding, and when two do, the non-current one has exactly one.
- R7: `bus_dret_en` has exactly one bit set. It selects the previous slave while that slave's leftover transaction is outstanding, and the current slave otherwise. A slave raises its bit of `bus_data_ack` only while its enable bit is high.
- R8: `rsp_valid` follows the data acknowledge of the enabled slave in the same cycle. `rsp_rdata` carries that slave's slice `bus_rdata[s*DW +: DW]`, and `rsp_slave` carries its index.
- R9: Responses reach the client in the order the requests were accepted, across all slaves, and each read returns the data of its own address.
- R10: In the strict policy, a request to another slave is held until the current slave has no transaction outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Client request present |
| req_addr | input | AW | Client address; top bits pick the slave |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DW | Client write data |
| req_stall | output | 1 | Request present but not accepted this cycle |
| bus_valid | output | 1 | Command presented to the selected slave |
| bus_sel | output | SW | Index of the selected slave |
| bus_addr | output | AW | Command address |
| bus_we | output | 1 | Command direction |
| bus_wdata | output | DW | Command write data |
| bus_addr_ack | input | NSLV | Per-slave command-captured acknowledge |
| bus_data_ack | input | NSLV | Per-slave completion acknowledge |
| bus_rdata | input | NSLV*DW | Per-slave read data, slave s at s*DW |
| bus_dret_en | output | NSLV | Per-slave permission to complete |
| rsp_valid | output | 1 | Completion delivered to client |
| rsp_rdata | output | DW | Returned read data |
| rsp_slave | output | SW | Slave that completed |

## Verification
The main instance is built with four slaves, an 8-bit address, 16-bit data, MAX_OUT of 3 and the relaxed policy. With a depth of three, slow completions fill the pipeline within a few cycles, so the depth cap, the one-leftover switch and the held second switch all occur many times under every address pattern and latency mix. A second instance with the strict policy walks through the zero-leftover switch step by step. Slave models in the bench accept commands and return data with random delays, and the bench checks each cycle's issue, enable and response against counts it keeps itself.

// File: rtl/stm_pkg.sv
package stm_pkg;

    // Policy for leaving a slave that still owes completions.
    typedef enum logic {
        XPOL_RELAXED = 1'b0,   // one leftover completion allowed
        XPOL_STRICT  = 1'b1    // slave must be idle before switching
    } xpol_e;

endpackage

// File: rtl/stm_outstanding_tracker.sv
module stm_outstanding_tracker
    import stm_pkg::*;
#(
    parameter int    NSLV    = 4,
    parameter int    SW      = 2,
    parameter int    MAX_OUT = 15,
    parameter xpol_e POLICY  = XPOL_RELAXED
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [SW-1:0]   req_sel,
    input  logic [NSLV-1:0] addr_ack,
    input  logic [NSLV-1:0] data_ack,
    output logic            cmd_valid,
    output logic            accepted,
    output logic [NSLV-1:0] dret_en,
    output logic [SW-1:0]   ret_sel
);

    localparam int CW = $clog2(MAX_OUT + 1);
    localparam logic [CW-1:0] CAP = CW'(MAX_OUT);
    localparam logic [CW-1:0] LIM = (POLICY == XPOL_STRICT) ? '0 : CW'(1);

    typedef struct packed {
        logic [SW-1:0] cur;      // slave currently being streamed to
        logic [CW-1:0] cnt;      // its outstanding count
        logic          old_v;    // leftover completion owed by previous slave
        logic [SW-1:0] old_sel;  // which slave owes it
    } trk_t;

    trk_t st_q, st_d;

    logic same, permit, dack, cur_ret;

    always_comb begin
        st_d     = st_q;
        ret_sel  = st_q.old_v ? st_q.old_sel : st_q.cur;
        dret_en  = '0;
        dret_en[ret_sel] = 1'b1;
        dack     = data_ack[ret_sel];
        cur_ret  = dack && !st_q.old_v;
        same     = (req_sel == st_q.cur);
        permit   = same ? (st_q.cnt < CAP)
                        : (!st_q.old_v && (st_q.cnt <= LIM));
        cmd_valid = req_valid && permit;
        accepted  = cmd_valid && addr_ack[req_sel];

        if (st_q.old_v && dack) begin
            st_d.old_v = 1'b0;
        end

        if (accepted && !same) begin
            st_d.old_v   = (st_q.cnt != '0) && !cur_ret;
            st_d.old_sel = st_q.cur;
            st_d.cur     = req_sel;
            st_d.cnt     = CW'(1);
        end else begin
            st_d.cnt = st_q.cnt + CW'(accepted) - CW'(cur_ret);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4: the per-slave count never passes the configured depth
    a_r4_depth_cap: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CAP);

    // R5: a switch leaves the new slave current with exactly one in flight
    a_r5_switch_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && !same) |=> (st_q.cnt == CW'(1)) && (st_q.cur == $past(req_sel)));

    // R6: the leftover tag does not move while it is owed
    a_r6_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.old_v |=> (!st_q.old_v || $stable(st_q.old_sel)));

    // R7: exactly one slave may complete at a time
    a_r7_one_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(dret_en) == 1);

    // R7: slaves honour the completion enable
    a_r7_gate_obeyed: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ack & ~dret_en) == '0);

    generate
        if (POLICY == XPOL_STRICT) begin : g_strict_chk
            // R10: strict switching never leaves a leftover behind
            a_r10_no_leftover: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(st_q.cur != $past(st_q.cur)) |-> !st_q.old_v);
        end
    endgenerate

endmodule

// File: rtl/stm_return_mux.sv
module stm_return_mux #(
    parameter int NSLV = 4,
    parameter int SW   = 2,
    parameter int DW   = 32
) (
    input  logic [NSLV-1:0]    data_ack,
    input  logic [NSLV*DW-1:0] rdata_flat,
    input  logic [SW-1:0]      ret_sel,
    output logic               rsp_valid,
    output logic [DW-1:0]      rsp_rdata,
    output logic [SW-1:0]      rsp_slave
);

    logic [DW-1:0] lane [NSLV];

    generate
        for (genvar g = 0; g < NSLV; g++) begin : g_lane
            assign lane[g] = rdata_flat[g*DW +: DW];
        end
    endgenerate

    always_comb begin
        rsp_valid = data_ack[ret_sel];
        rsp_rdata = lane[ret_sel];
        rsp_slave = ret_sel;
    end

endmodule

// File: rtl/stm_split_master.sv
module stm_split_master
    import stm_pkg::*;
#(
    parameter int    AW      = 16,
    parameter int    DW      = 32,
    parameter int    NSLV    = 4,
    parameter int    MAX_OUT = 15,
    parameter xpol_e POLICY  = XPOL_RELAXED,
    localparam int   SW      = (NSLV > 1) ? $clog2(NSLV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [AW-1:0]      req_addr,
    input  logic               req_we,
    input  logic [DW-1:0]      req_wdata,
    output logic               req_stall,
    output logic               bus_valid,
    output logic [SW-1:0]      bus_sel,
    output logic [AW-1:0]      bus_addr,
    output logic               bus_we,
    output logic [DW-1:0]      bus_wdata,
    input  logic [NSLV-1:0]    bus_addr_ack,
    input  logic [NSLV-1:0]    bus_data_ack,
    input  logic [NSLV*DW-1:0] bus_rdata,
    output logic [NSLV-1:0]    bus_dret_en,
    output logic               rsp_valid,
    output logic [DW-1:0]      rsp_rdata,
    output logic [SW-1:0]      rsp_slave
);

    logic [SW-1:0] sel;
    logic [SW-1:0] ret_sel;
    logic          accepted;

    assign sel       = req_addr[AW-1 -: SW];
    assign bus_sel   = sel;
    assign bus_addr  = req_addr;
    assign bus_we    = req_we;
    assign bus_wdata = req_wdata;
    assign req_stall = req_valid && !accepted;

    stm_outstanding_tracker #(
        .NSLV(NSLV), .SW(SW), .MAX_OUT(MAX_OUT), .POLICY(POLICY)
    ) trk_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_sel  (sel),
        .addr_ack (bus_addr_ack),
        .data_ack (bus_data_ack),
        .cmd_valid(bus_valid),
        .accepted (accepted),
        .dret_en  (bus_dret_en),
        .ret_sel  (ret_sel)
    );

    stm_return_mux #(
        .NSLV(NSLV), .SW(SW), .DW(DW)
    ) rmux_i (
        .data_ack  (bus_data_ack),
        .rdata_flat(bus_rdata),
        .ret_sel   (ret_sel),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .rsp_slave (rsp_slave)
    );

endmodule

// File: tb/stm_split_master_tb.sv
module stm_split_master_tb_top;
    import stm_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 8, DW = 16, NS = 4, MO = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    int vectors = 0, miscompares = 0;
    bit done = 1'b0;

    // relaxed instance
    logic           req_valid = 0, req_we = 0;
    logic [AW-1:0]  req_addr = 0;
    logic [DW-1:0]  req_wdata = 0;
    logic           req_stall, bus_valid, bus_we, rsp_valid;
    logic [1:0]     bus_sel, rsp_slave;
    logic [AW-1:0]  bus_addr;
    logic [DW-1:0]  bus_wdata, rsp_rdata;
    logic [NS-1:0]  addr_ack = 0, data_ack = 0, dret_en;
    logic [NS*DW-1:0] rdata = 0;

    stm_split_master #(.AW(AW), .DW(DW), .NSLV(NS), .MAX_OUT(MO), .POLICY(XPOL_RELAXED)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata), .req_stall(req_stall),
        .bus_valid(bus_valid), .bus_sel(bus_sel), .bus_addr(bus_addr),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_addr_ack(addr_ack),
        .bus_data_ack(data_ack), .bus_rdata(rdata), .bus_dret_en(dret_en),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_slave(rsp_slave));

    // strict instance
    logic           s_req_valid = 0;
    logic [AW-1:0]  s_req_addr = 0;
    logic           s_stall, s_bus_valid, s_bus_we, s_rsp_valid;
    logic [1:0]     s_bus_sel, s_rsp_slave;
    logic [AW-1:0]  s_bus_addr;
    logic [DW-1:0]  s_bus_wdata, s_rsp_rdata;
    logic [NS-1:0]  s_addr_ack = 0, s_data_ack = 0, s_dret_en;

    stm_split_master #(.AW(AW), .DW(DW), .NSLV(NS), .MAX_OUT(MO), .POLICY(XPOL_STRICT)) dut_s_i (
        .clk(clk), .rst_n(rst_n), .req_valid(s_req_valid), .req_addr(s_req_addr),
        .req_we(1'b0), .req_wdata('0), .req_stall(s_stall),
        .bus_valid(s_bus_valid), .bus_sel(s_bus_sel), .bus_addr(s_bus_addr),
        .bus_we(s_bus_we), .bus_wdata(s_bus_wdata), .bus_addr_ack(s_addr_ack),
        .bus_data_ack(s_data_ack), .bus_rdata({NS{16'hBEEF}}), .bus_dret_en(s_dret_en),
        .rsp_valid(s_rsp_valid), .rsp_rdata(s_rsp_rdata), .rsp_slave(s_rsp_slave));

    // bench-side slave models and scoreboard
    logic [DW-1:0] pdat [NS][16];
    int phead [NS];
    int pcnt  [NS];
    int bcur = 0;
    int aprob = 100, dprob = 100;
    int exp_sl [$];
    int exp_we [$];
    int exp_dat [$];

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, expv, $time);
        end
    endtask

    function automatic logic [DW-1:0] rd_val(input logic [AW-1:0] a);
        return {a ^ 8'h5A, ~a};
    endfunction

    task automatic cycle(input bit have, input logic [AW-1:0] a, input bit we, output bit took);
        logic [NS-1:0] dk, ak, exp_en;
        int other, sl, rs;
        bit permit;
        @(negedge clk);
        req_valid = have; req_addr = a; req_we = we; req_wdata = {a, ~a};
        dk = '0;
        for (int s = 0; s < NS; s++) begin
            if (pcnt[s] > 0 && dret_en[s] && $urandom_range(99) < dprob) dk[s] = 1'b1;
            rdata[s*DW +: DW] = dk[s] ? pdat[s][phead[s]] : DW'($urandom);
        end
        data_ack = dk; addr_ack = '0;
        #1;
        other = -1;
        for (int s = 0; s < NS; s++) if (s != bcur && pcnt[s] > 0) other = s;
        sl = int'(a[AW-1 -: 2]);
        permit = (sl == bcur) ? (pcnt[bcur] < MO) : (other < 0 && pcnt[bcur] <= 1);
        if (sl == bcur)
            chk(bus_valid == (have && permit), "R4 issue to current slave", int'(bus_valid), int'(have && permit));
        else
            chk(bus_valid == (have && permit), "R5/R6 issue to other slave", int'(bus_valid), int'(have && permit));
        exp_en = '0;
        exp_en[(other >= 0) ? other : bcur] = 1'b1;
        chk(dret_en == exp_en, "R7 completion enable", int'(dret_en), int'(exp_en));
        if (have) begin
            chk(int'(bus_sel) == sl && bus_addr == a && bus_we == we && bus_wdata == {a, ~a},
                "R2 command pass-through", int'(bus_sel), sl);
        end
        ak = '0;
        if (bus_valid && $urandom_range(99) < aprob) ak[bus_sel] = 1'b1;
        addr_ack = ak;
        #1;
        took = have && !req_stall;
        chk(took == (have && permit && ak != 0), "R3 acceptance", int'(took), int'(have && permit && ak != 0));
        chk(rsp_valid == (dk != 0), "R8 response strobe", int'(rsp_valid), int'(dk != 0));
        if (dk != 0) begin
            rs = (other >= 0) ? other : bcur;
            chk(int'(rsp_slave) == exp_sl[0], "R9 response order", int'(rsp_slave), exp_sl[0]);
            if (exp_we[0] == 0)
                chk(rsp_rdata == DW'(exp_dat[0]), "R8 read data", int'(rsp_rdata), exp_dat[0]);
            void'(exp_sl.pop_front()); void'(exp_we.pop_front()); void'(exp_dat.pop_front());
            phead[rs] = (phead[rs] + 1) % 16;
            pcnt[rs]--;
        end
        if (took) begin
            pdat[sl][(phead[sl] + pcnt[sl]) % 16] = we ? '0 : rd_val(a);
            pcnt[sl]++;
            exp_sl.push_back(sl); exp_we.push_back(int'(we));
            exp_dat.push_back(we ? 0 : int'(rd_val(a)));
            bcur = sl;
        end
        begin
            int busy = 0, ok6 = 1;
            for (int s = 0; s < NS; s++) if (pcnt[s] > 0) begin
                busy++;
                if (s != bcur && pcnt[s] != 1) ok6 = 0;
            end
            if (busy > 2) ok6 = 0;
            chk(ok6 == 1, "R6 outstanding limit", busy, 2);
        end
    endtask

    initial begin
        bit took;
        for (int s = 0; s < NS; s++) begin phead[s] = 0; pcnt[s] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(bus_valid == 0 && rsp_valid == 0, "R1 idle after reset", int'(bus_valid), 0);
        chk(dret_en == 4'b0001, "R1 enable after reset", int'(dret_en), 1);
        chk(s_bus_valid == 0 && s_dret_en == 4'b0001, "R1 strict idle", int'(s_dret_en), 1);

        // strict policy walk-through
        @(negedge clk);
        s_req_valid = 1; s_req_addr = 8'h05; s_addr_ack = 4'b0001;
        #1 chk(s_stall == 0, "R10 first accept", int'(s_stall), 0);
        @(negedge clk);
        s_addr_ack = 0; s_req_addr = 8'h45;
        #1 chk(s_bus_valid == 0, "R10 switch held at one outstanding", int'(s_bus_valid), 0);
        chk(s_dret_en == 4'b0001, "R7 strict enable", int'(s_dret_en), 1);
        @(negedge clk);
        s_data_ack = 4'b0001;
        #1 chk(s_rsp_valid == 1 && s_rsp_slave == 0, "R8 strict completion", int'(s_rsp_valid), 1);
        chk(s_bus_valid == 0, "R10 still held in completion cycle", int'(s_bus_valid), 0);
        @(negedge clk);
        s_data_ack = 0;
        #1 chk(s_bus_valid == 1, "R10 switch issued when idle", int'(s_bus_valid), 1);
        s_addr_ack = 4'b0010;
        #1 chk(s_stall == 0, "R3 strict switch accepted", int'(s_stall), 0);
        @(negedge clk);
        s_req_valid = 0; s_addr_ack = 0;
        #1 chk(s_dret_en == 4'b0010, "R7 strict enable follows new slave", int'(s_dret_en), 2);

        // sweeps: address pattern x latency mix
        for (int pat = 0; pat < 4; pat++) begin
            for (int lat = 0; lat < 4; lat++) begin
                case (lat)
                    0: begin aprob = 100; dprob = 100; end
                    1: begin aprob = 50;  dprob = 50;  end
                    2: begin aprob = 30;  dprob = 80;  end
                    default: begin aprob = 100; dprob = 15; end
                endcase
                for (int k = 0; k < 120; k++) begin
                    logic [1:0] sl;
                    logic [AW-1:0] a;
                    bit we;
                    case (pat)
                        0: sl = 2'($urandom_range(3));
                        1: sl = 2'(k % 2);
                        2: sl = 2'((k / 5) % 4);
                        default: sl = 2'd2;
                    endcase
                    a = {sl, 6'($urandom)};
                    we = 1'($urandom);
                    took = 0;
                    while (!took) cycle(1'b1, a, we, took);
                end
                while (pcnt[0] + pcnt[1] + pcnt[2] + pcnt[3] > 0) cycle(1'b0, '0, 1'b0, took);
            end
        end
        chk(exp_sl.size() == 0, "R9 all responses delivered", exp_sl.size(), 0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL R9 watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule